// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address. It walks a radix translation tree that lives in ordinary memory. A request carries the effective address, a partition identifier, a process identifier and a store flag. The walker first reads the process-table pointer from the partition table, which is located through an internal table control register. It then reads the process table entry that holds the tree root. Before it reads any directory, it screens the address against the tree size and checks the encoded root size. It then descends one directory level per memory read until it finds a leaf or hits an error.

All reads are single 64-bit doublewords on a plain request/ready, response/valid memory port, with one read in flight at a time. The result appears on a one-cycle completion pulse. That pulse carries the real address, the raw leaf entry, the echoed store flag and a 3-bit error code.

Field positions below use bit 0 as the most significant bit of a 64-bit word. Permission decisions, translation caching and reference/change updates are left to the neighbouring blocks.

Top module: `radix_walker`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low, and no memory read is issued while it is high, until the cycle after the completion pulse.
- R2: The table control register is loaded from `tcr_wdata` when `tcr_we` is high. Its bits 4..51, shifted left by 12, form the partition table base. The first read of a walk goes to that base + 16·LPID + 8, which is the second doubleword of the partition entry. A write made in the same cycle that a request is taken applies to that walk.
- R3: In that doubleword, bits 4..51 give the process table base field and bits 59..63 give its size code S. The process table base is (field with its low S bits cleared) << 12. The second read goes to that base + 16·PID.
- R4: The process table entry that is read is the root. Its tree size is the 5-bit value {bits 1..2, bits 56..58} + 31, which is the count of translated address bits. Its directory base is bits 4..55 << 8. Its log2 directory entry count is bits 59..63.
- R5: Segment screen, applied to little-endian address bits. If bit 63 differs from bit 62, the walk ends with error 1. If any bit from the tree size up to bit 61 is set, the walk also ends with error 1. Error 1 takes precedence over a bad root size.
- R6: A directory size of less than 5, more than 16, or more than the still-unresolved address bits above the 12-bit page offset ends the walk with error 2. This applies to the root size and to every non-leaf next-level size.
- R7: A directory read goes to base + 8·index. The index is the next size-wide slice of the address, taken just below the bits already resolved. A non-leaf entry (bit 0 = valid = 1, bit 1 = leaf = 0) supplies the next base (bits 4..55 << 8) and the next size (bits 59..63).
- R8: For a leaf entry (bits 0 and 1 both set), the real address is (bits 7..51 << 12) OR the address bits below the resolved part. Error is 0, and the raw entry is returned.
- R9: A directory entry with bit 0 clear ends the walk with error 3.
- R10: A read request holds its address stable until `mem_ready` is seen. No new request is raised while a response is still outstanding.
- R11: `done` is high for exactly one cycle per walk. It carries `done_err` (0 none, 1 segment, 2 bad tree, 3 no entry), `done_ra`, `done_pte` and the store flag from the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tcr_we | input | 1 | Table control register write enable |
| tcr_wdata | input | 64 | Table control register write value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_ea | input | 64 | Effective address to translate |
| req_lpid | input | LPID_W | Partition identifier |
| req_pid | input | PID_W | Process identifier |
| req_store | input | 1 | Access is a store |
| mem_req | output | 1 | Doubleword read request |
| mem_addr | output | 64 | Read byte address |
| mem_ready | input | 1 | Memory takes the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 3 | Completion code |
| done_ra | output | 64 | Real address (valid when code is 0) |
| done_pte | output | 64 | Leaf entry (valid when code is 0) |
| done_store | output | 1 | Store flag of the finished request |

## Verification
A write to the table control register and the acceptance of a request can happen on the same clock edge. The design must then make the new partition base govern the walk that has just started. The bench raises `tcr_we` with a different base in the very cycle that `req_valid` meets `req_ready`. It then judges the outcome in two ways: the first read address must be built from the new base, and the walk must end in the segment error that the empty new tables imply. It then restores the old base, repeats the same request and expects the original real address.

// File: rtl/rpw_pkg.sv
package rpw_pkg;

  localparam int PAGE_BITS = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_PATE, ST_READ_PRTE, ST_SEG_CHECK, ST_LOOKUP, ST_WAIT_MEM, ST_DONE
  } rpw_state_e;

  typedef enum logic [1:0] {FETCH_PATE, FETCH_PRTE, FETCH_DIR} rpw_fetch_e;

  localparam logic [2:0] ERR_NONE    = 3'd0;
  localparam logic [2:0] ERR_SEG     = 3'd1;
  localparam logic [2:0] ERR_BADTREE = 3'd2;
  localparam logic [2:0] ERR_NOENT   = 3'd3;

  // partition table byte base from the 48-bit base field
  function automatic logic [63:0] tbl_base(input logic [47:0] fld);
    return {4'b0, fld, 12'b0};
  endfunction

  // process table base: clear low size-code bits of the field, then scale to bytes
  function automatic logic [63:0] prt_base(input logic [63:0] w);
    logic [47:0] fld;
    fld = w[59:12] & ~((48'd1 << w[4:0]) - 48'd1);
    return {4'b0, fld, 12'b0};
  endfunction

  function automatic logic [63:0] dir_base(input logic [63:0] w);
    return {4'b0, w[59:8], 8'b0};
  endfunction

  function automatic logic [5:0] tree_bits(input logic [63:0] w);
    return 6'({w[62:61], w[7:5]}) + 6'd31;
  endfunction

  function automatic logic size_bad(input logic [4:0] sz, input logic [5:0] rem,
                                    input logic [4:0] mn, input logic [4:0] mx);
    return (sz < mn) || (sz > mx) || ({1'b0, sz} > rem);
  endfunction

  function automatic logic [63:0] entry_addr(input logic [63:0] base, input logic [63:0] ea,
                                             input logic [5:0] rem, input logic [4:0] sz);
    logic [63:0] idx;
    int sh;
    sh  = PAGE_BITS + int'(rem) - int'(sz);
    idx = (ea >> sh) & ((64'd1 << sz) - 64'd1);
    return base + (idx << 3);
  endfunction

  function automatic logic [63:0] leaf_ra(input logic [63:0] w, input logic [63:0] ea,
                                          input logic [5:0] rem);
    logic [63:0] keep;
    keep = (64'd1 << (PAGE_BITS + int'(rem))) - 64'd1;
    return {7'b0, w[56:12], 12'b0} | (ea & keep);
  endfunction

  function automatic logic seg_fault(input logic [63:0] ea, input logic [5:0] rts);
    logic [63:0] upper;
    upper = ~((64'd1 << rts) - 64'd1) & 64'h3FFF_FFFF_FFFF_FFFF;
    return (ea[63] != ea[62]) || ((ea & upper) != 64'd0);
  endfunction

endpackage

// File: rtl/rpw_entry_decode.sv
module rpw_entry_decode
  import rpw_pkg::*;
(
  input  logic [63:0] ent,
  output logic        ent_valid,
  output logic        ent_leaf,
  output logic [5:0]  ent_tree,
  output logic [63:0] ent_base,
  output logic [4:0]  ent_size,
  output logic [63:0] ent_proc_base
);
  assign ent_valid     = ent[63];
  assign ent_leaf      = ent[62];
  assign ent_tree      = tree_bits(ent);
  assign ent_base      = dir_base(ent);
  assign ent_size      = ent[4:0];
  assign ent_proc_base = prt_base(ent);

  logic unused_ent;
  assign unused_ent = ent[60];
endmodule

// File: rtl/rpw_screen.sv
module rpw_screen
  import rpw_pkg::*;
#(
  parameter int SIZE_MIN = 5,
  parameter int SIZE_MAX = 16
) (
  input  logic [63:0] ea,
  input  logic [5:0]  rts,
  input  logic [4:0]  root_size,
  output logic        seg_err,
  output logic        tree_err,
  output logic [5:0]  rem_init
);
  assign rem_init = rts - 6'(PAGE_BITS);
  assign seg_err  = seg_fault(ea, rts);
  assign tree_err = size_bad(root_size, rem_init, 5'(SIZE_MIN), 5'(SIZE_MAX));
endmodule

// File: rtl/rpw_addr_gen.sv
module rpw_addr_gen
  import rpw_pkg::*;
#(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20,
  parameter int ENTRY_LOG2 = 4
) (
  input  rpw_state_e        state,
  input  logic [47:0]       pt_field,
  input  logic [LPID_W-1:0] lpid,
  input  logic [PID_W-1:0]  pid,
  input  logic [63:0]       base,
  input  logic [63:0]       ea,
  input  logic [5:0]        rem,
  input  logic [4:0]        size,
  output logic [63:0]       addr
);
  localparam logic [63:0] SECOND_DW = 64'd8;

  logic [63:0] pate_addr, prte_addr, dir_addr;

  assign pate_addr = tbl_base(pt_field) + (64'(lpid) << ENTRY_LOG2) + SECOND_DW;
  assign prte_addr = base + (64'(pid) << ENTRY_LOG2);
  assign dir_addr  = entry_addr(base, ea, rem, size);

  always_comb begin
    case (state)
      ST_READ_PATE: addr = pate_addr;
      ST_READ_PRTE: addr = prte_addr;
      ST_LOOKUP:    addr = dir_addr;
      default:      addr = 64'd0;
    endcase
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rpw_pkg::*;
#(
  parameter int LPID_W   = 12,
  parameter int PID_W    = 20,
  parameter int SIZE_MIN = 5,
  parameter int SIZE_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tcr_we,
  input  logic [63:0]       tcr_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_ea,
  input  logic [LPID_W-1:0] req_lpid,
  input  logic [PID_W-1:0]  req_pid,
  input  logic              req_store,
  output logic              mem_req,
  output logic [63:0]       mem_addr,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              done,
  output logic [2:0]        done_err,
  output logic [63:0]       done_ra,
  output logic [63:0]       done_pte,
  output logic              done_store
);
  localparam int ENTRY_LOG2 = 4;

  rpw_state_e        state_q;
  rpw_fetch_e        fetch_q;
  logic [47:0]       pt_field_q;
  logic [63:0]       ea_q, base_q;
  logic [LPID_W-1:0] lpid_q;
  logic [PID_W-1:0]  pid_q;
  logic              store_q;
  logic [5:0]        rts_q, rem_q;
  logic [4:0]        size_q;
  logic [2:0]        err_q;
  logic [63:0]       ra_q, pte_q;

  // named events
  logic walk_start, mem_fire, resp_dir;
  assign walk_start = req_valid && req_ready;
  assign mem_fire   = mem_req && mem_ready;
  assign resp_dir   = (state_q == ST_WAIT_MEM) && mem_rvalid && (fetch_q == FETCH_DIR);

  logic        dec_valid, dec_leaf;
  logic [5:0]  dec_tree;
  logic [63:0] dec_base, dec_proc_base;
  logic [4:0]  dec_size;

  rpw_entry_decode u_dec (
    .ent(mem_rdata), .ent_valid(dec_valid), .ent_leaf(dec_leaf), .ent_tree(dec_tree),
    .ent_base(dec_base), .ent_size(dec_size), .ent_proc_base(dec_proc_base)
  );

  logic       scr_seg, scr_tree;
  logic [5:0] scr_rem;

  rpw_screen #(.SIZE_MIN(SIZE_MIN), .SIZE_MAX(SIZE_MAX)) u_scr (
    .ea(ea_q), .rts(rts_q), .root_size(size_q),
    .seg_err(scr_seg), .tree_err(scr_tree), .rem_init(scr_rem)
  );

  rpw_addr_gen #(.LPID_W(LPID_W), .PID_W(PID_W), .ENTRY_LOG2(ENTRY_LOG2)) u_agen (
    .state(state_q), .pt_field(pt_field_q), .lpid(lpid_q), .pid(pid_q),
    .base(base_q), .ea(ea_q), .rem(rem_q), .size(size_q), .addr(mem_addr)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_READ_PATE) || (state_q == ST_READ_PRTE) ||
                      (state_q == ST_LOOKUP);
  assign done       = (state_q == ST_DONE);
  assign done_err   = err_q;
  assign done_ra    = ra_q;
  assign done_pte   = pte_q;
  assign done_store = store_q;

  logic unused_tcr;
  assign unused_tcr = ^{tcr_wdata[63:60], tcr_wdata[11:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pt_field_q <= '0;
    else if (tcr_we) pt_field_q <= tcr_wdata[59:12];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fetch_q <= FETCH_PATE;
      ea_q    <= '0;
      base_q  <= '0;
      lpid_q  <= '0;
      pid_q   <= '0;
      store_q <= 1'b0;
      rts_q   <= '0;
      rem_q   <= '0;
      size_q  <= '0;
      err_q   <= ERR_NONE;
      ra_q    <= '0;
      pte_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (walk_start) begin
          ea_q    <= req_ea;
          lpid_q  <= req_lpid;
          pid_q   <= req_pid;
          store_q <= req_store;
          state_q <= ST_READ_PATE;
        end
        ST_READ_PATE: if (mem_fire) begin
          fetch_q <= FETCH_PATE;
          state_q <= ST_WAIT_MEM;
        end
        ST_READ_PRTE: if (mem_fire) begin
          fetch_q <= FETCH_PRTE;
          state_q <= ST_WAIT_MEM;
        end
        ST_LOOKUP: if (mem_fire) begin
          fetch_q <= FETCH_DIR;
          rem_q   <= rem_q - {1'b0, size_q};
          state_q <= ST_WAIT_MEM;
        end
        ST_SEG_CHECK: begin
          if (scr_seg) begin
            err_q <= ERR_SEG; ra_q <= '0; pte_q <= '0; state_q <= ST_DONE;
          end else if (scr_tree) begin
            err_q <= ERR_BADTREE; ra_q <= '0; pte_q <= '0; state_q <= ST_DONE;
          end else begin
            rem_q   <= scr_rem;
            state_q <= ST_LOOKUP;
          end
        end
        ST_WAIT_MEM: if (mem_rvalid) begin
          case (fetch_q)
            FETCH_PATE: begin
              base_q  <= dec_proc_base;
              state_q <= ST_READ_PRTE;
            end
            FETCH_PRTE: begin
              base_q  <= dec_base;
              size_q  <= dec_size;
              rts_q   <= dec_tree;
              state_q <= ST_SEG_CHECK;
            end
            default: begin
              if (!dec_valid) begin
                err_q <= ERR_NOENT; ra_q <= '0; pte_q <= '0; state_q <= ST_DONE;
              end else if (dec_leaf) begin
                err_q   <= ERR_NONE;
                ra_q    <= leaf_ra(mem_rdata, ea_q, rem_q);
                pte_q   <= mem_rdata;
                state_q <= ST_DONE;
              end else if (size_bad(dec_size, rem_q, 5'(SIZE_MIN), 5'(SIZE_MAX))) begin
                err_q <= ERR_BADTREE; ra_q <= '0; pte_q <= '0; state_q <= ST_DONE;
              end else begin
                base_q  <= dec_base;
                size_q  <= dec_size;
                state_q <= ST_LOOKUP;
              end
            end
          endcase
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rpw_walker_chk.sv
module rpw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        walk_start,
  input logic [63:0] req_ea,
  input logic        mem_req,
  input logic        mem_ready,
  input logic [63:0] mem_addr,
  input logic        mem_rvalid,
  input logic        done,
  input logic [2:0]  done_err,
  input logic [63:0] done_ra
);
  logic        pending_q;
  logic [63:0] ea_cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      ea_cap_q  <= '0;
    end else begin
      if (mem_req && mem_ready) pending_q <= 1'b1;
      else if (mem_rvalid)      pending_q <= 1'b0;
      if (walk_start) ea_cap_q <= req_ea;
    end
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !req_ready);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pending_q);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_err <= 3'd3));

  assert_page_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == 3'd0) |-> (done_ra[11:0] == ea_cap_q[11:0]));
endmodule

bind radix_walker rpw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .walk_start(walk_start),
  .req_ea(req_ea), .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .done(done), .done_err(done_err), .done_ra(done_ra)
);

// File: tb/radix_walker_tb.sv
module radix_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam int NM = 13;

  // memory image (byte address, doubleword)
  localparam logic [63:0] M_ADDR [NM] = '{
    64'h10018, 64'h10028, 64'h20030, 64'h20040, 64'h20050, 64'h30008, 64'h30010,
    64'h30018, 64'h40010, 64'h41000, 64'h50018, 64'h50028, 64'h60020};
  localparam logic [63:0] M_DATA [NM] = '{
    64'h0000_0000_0002_0000, 64'h0000_0000_0002_1001, 64'h4000_0000_0003_00AD,
    64'h4000_0000_0003_00A4, 64'h4000_0000_0003_00A4, 64'h8000_0000_0004_0009,
    64'h8000_0000_0004_1010, 64'h8000_0000_0004_0004, 64'h8000_0000_0005_0009,
    64'h8000_0000_0004_200C, 64'h8000_0000_0006_0009, 64'hC000_0000_7760_0000,
    64'hC000_0000_1234_5000};

  // vectors: 0 4K leaf R7 R8; 1 large leaf R8 store echo R11; 2 no entry R9;
  // 3,4 segment R5; 5 equal top bits pass R5; 6 size-code masking R3;
  // 7 root size too small R4 R6; 8 level size above remaining R6;
  // 9 level size below minimum R6; 10 segment before bad tree R5
  localparam logic [63:0] V_EA [NV] = '{
    64'h0000_0080_8060_4123, 64'h0000_0080_80BA_BCDE, 64'h0000_0080_80C0_0000,
    64'h8000_0000_0000_0000, 64'h0080_0000_0000_0000, 64'hC000_0000_0000_0000,
    64'h0000_0080_8060_4123, 64'h0000_0080_8060_4123, 64'h0000_0100_0000_0000,
    64'h0000_0180_0000_0000, 64'h8000_0000_0000_0000};
  localparam logic [11:0] V_LPID [NV] = '{1, 1, 1, 1, 1, 1, 2, 1, 1, 1, 1};
  localparam logic [19:0] V_PID  [NV] = '{3, 3, 3, 3, 3, 3, 3, 4, 3, 3, 5};
  localparam logic        V_ST   [NV] = '{0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0};
  localparam logic [2:0]  V_ERR  [NV] = '{0, 0, 3, 1, 1, 3, 0, 2, 2, 2, 1};
  localparam logic [63:0] V_RA   [NV] = '{
    64'h1234_5123, 64'h777A_BCDE, 0, 0, 0, 0, 64'h1234_5123, 0, 0, 0, 0};
  localparam int          V_REQ  [NV] = '{8, 8, 9, 5, 5, 5, 3, 6, 6, 6, 5};

  logic clk = 1'b0, rst_n = 1'b0;
  logic tcr_we = 1'b0;
  logic [63:0] tcr_wdata = '0;
  logic req_valid = 1'b0, req_store = 1'b0;
  logic [63:0] req_ea = '0;
  logic [11:0] req_lpid = '0;
  logic [19:0] req_pid = '0;
  logic req_ready, mem_req, done, done_store;
  logic [63:0] mem_addr, done_ra, done_pte;
  logic [2:0] done_err;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [7:0] cyc = '0;
  logic mem_ready;

  int n_chk = 0, n_fail = 0;
  logic [2:0] got_err;
  logic [63:0] got_ra, got_pte, first_addr;
  logic got_store, ready_seen, late_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  radix_walker u_dut (
    .clk(clk), .rst_n(rst_n), .tcr_we(tcr_we), .tcr_wdata(tcr_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_lpid(req_lpid), .req_pid(req_pid), .req_store(req_store),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
    .done_err(done_err), .done_ra(done_ra), .done_pte(done_pte), .done_store(done_store)
  );

  function automatic logic [63:0] mem_lookup(input logic [63:0] a);
    logic [63:0] r = '0;
    for (int i = 0; i < NM; i++) if (M_ADDR[i] == a) r = M_DATA[i];
    return r;
  endfunction

  // stalling memory: busy one cycle in four, response one cycle after acceptance
  assign mem_ready = (cyc[1:0] != 2'b11);
  always @(posedge clk) begin
    cyc        <= cyc + 8'd1;
    mem_rvalid <= mem_req && mem_ready;
    mem_rdata  <= mem_lookup(mem_addr);
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_walk(input logic [63:0] ea, input logic [11:0] lpid,
                          input logic [19:0] pid, input logic st,
                          input logic wr_tcr, input logic [63:0] tcr_val);
    int t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_lpid = lpid; req_pid = pid; req_store = st;
    if (wr_tcr) begin tcr_we = 1'b1; tcr_wdata = tcr_val; end
    @(negedge clk);
    req_valid = 1'b0; tcr_we = 1'b0;
    first_addr = '0; ready_seen = 1'b0;
    t = 0;
    while (!done && t < 500) begin
      if (mem_req && first_addr == 64'd0) first_addr = mem_addr;
      if (req_ready) ready_seen = 1'b1;
      @(negedge clk);
      t++;
    end
    if (t >= 500) begin
      n_chk++; n_fail++;
      $display("FAIL R11 walk timeout actual=no done expected=done");
    end
    got_err = done_err; got_ra = done_ra; got_pte = done_pte; got_store = done_store;
    @(negedge clk);
    late_done = done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R1, R10, R11)
    check("R1 reset ready", 64'(req_ready), 64'd1);
    check("R11 reset done", 64'(done), 64'd0);
    check("R10 reset mem_req", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    tcr_we = 1'b1; tcr_wdata = 64'h0000_0000_0001_0000;
    @(negedge clk);
    tcr_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_walk(V_EA[i], V_LPID[i], V_PID[i], V_ST[i], 1'b0, '0);
      check($sformatf("R%0d vec%0d err", V_REQ[i], i), 64'(got_err), 64'(V_ERR[i]));
      if (V_ERR[i] == 3'd0)
        check($sformatf("R%0d vec%0d ra", V_REQ[i], i), got_ra, V_RA[i]);
      check($sformatf("R11 vec%0d store", i), 64'(got_store), 64'(V_ST[i]));
      check($sformatf("R11 vec%0d pulse", i), 64'(late_done), 64'd0);
    end

    // directed: first read address, busy indication, leaf entry returned
    run_walk(V_EA[0], 12'd1, 20'd3, 1'b0, 1'b0, '0);
    check("R2 first read addr", first_addr, 64'h10018);
    check("R1 ready low while walking", 64'(ready_seen), 64'd0);
    check("R8 leaf entry", got_pte, 64'hC000_0000_1234_5000);
    check("R4 R7 4K walk ra", got_ra, 64'h1234_5123);

    // directed: table control write in the acceptance cycle (R2)
    run_walk(V_EA[0], 12'd1, 20'd3, 1'b0, 1'b1, 64'h0000_0000_0009_0000);
    check("R2 same-cycle write addr", first_addr, 64'h90018);
    check("R2 same-cycle write err", 64'(got_err), 64'd1);

    // restore and repeat (R2)
    @(negedge clk);
    tcr_we = 1'b1; tcr_wdata = 64'h0000_0000_0001_0000;
    @(negedge clk);
    tcr_we = 1'b0;
    run_walk(V_EA[0], 12'd1, 20'd3, 1'b1, 1'b0, '0);
    check("R2 restored err", 64'(got_err), 64'd0);
    check("R2 restored ra", got_ra, 64'h1234_5123);
    check("R11 restored store", 64'(got_store), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule